// File: doc/BRIEF.md
# Size-Aware Condition Flag Evaluator

This block turns the operands and result of an instruction that has already finished into the processor's condition flags. It knows nothing about how the result was produced. Instead it reads the operation class, the operand width (byte, halfword or word), the source and destination operands, the result, the high word of a multiply, the current extend flag and a flag-update mask. It evaluates negative, zero, overflow and carry from sign bits, following fixed rules for each class. It then merges the outcome into a held status register on a strobe.

Carry and overflow are not taken from a carry chain. They come from the most significant bits of the operands and the result at the selected width. Subtract-style classes invert the source before the sign rules and flip the carry afterwards. Multiplies look at the 64-bit value formed from the high word and the result. One class leaves the flags untouched because they are already up to date. A block-copy class reports its carry-style outcome in a separate flag instead of carry. Extended arithmetic can protect an earlier zero flag from being overwritten.

Status bit positions: C = bit 0, V = bit 1, Z = bit 2, N = bit 3, X = bit 4, R = bit 8.

Class codes on `op_class`:
- 0 add
- 1 subtract
- 2 compare
- 3 add-with-carry
- 4 move
- 5 logic
- 6 shift
- 7 signed multiply
- 8 unsigned multiply
- 9 block copy
- 10 flags-live
- 11 to 15 act as arithmetic classes, with no inversion and no recompute.

Size codes on `op_size`: 0 byte, 1 halfword, 2 word, 3 reserved.

Top module: `cc_flag_engine`

## Requirements
- R1: While reset is asserted and after it is released, the status register reads zero.
- R2: For arithmetic classes at the selected width, the result MSB decides the branch. If the MSB is set, N=1, V is set when neither operand MSB is set, and C is set when both are set. If the MSB is clear, Z is set when the result is zero within the width, V is set when both operand MSBs are set, and C is set when either operand MSB is set.
- R3: Subtract (1) and compare (2) invert the source operand before the R2 rules and invert C afterwards.
- R4: At word size, add uses dst+src and subtract uses dst-src in place of the result input. Compare, add-with-carry and every narrower size use the result input.
- R5: Block copy (9) always applies the R2 rules at word size. Its carry-style outcome goes to R (bit 8), and C receives 0 when the mask selects it.
- R6: Move, logic and shift (4, 5, 6) at halfword or word size produce only N (the result MSB) and Z (result zero within the width, only when N is clear); V and C are produced as 0. At byte size these classes use the R2 rules without inversion.
- R7: Signed multiply (7) forms the 64-bit value {mul_hi, result}. Z is set when that value is zero, otherwise N takes bit 63. V is set when mul_hi is not the sign extension of result.
- R8: Unsigned multiply (8) sets Z and N exactly as in R7, and sets V whenever mul_hi is nonzero.
- R9: When `x_flag` is 1 or the class is add-with-carry, and Z was computed as 1, the Z bit is removed from the mask so the stored Z keeps its old value.
- R10: On a strobe, every masked bit and the X bit are cleared, then the computed flags ANDed with the mask are ORed in. Unmasked bits keep their value. Without a strobe the status does not change.
- R11: The flags-live class (10) leaves the whole status unchanged, X included.
- R12: The reserved size code evaluates no sign rules, so N, Z, V and C are computed as 0. Subtract and compare still apply the C inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_valid | input | 1 | Strobe: merge the evaluated flags this cycle |
| op_class | input | 4 | Operation class code |
| op_size | input | 2 | Operand width code |
| src_opnd | input | DATA_W | Source operand |
| dst_opnd | input | DATA_W | Destination operand |
| result | input | DATA_W | Operation result |
| mul_hi | input | DATA_W | High word of a multiply product |
| x_flag | input | 1 | Current extend flag |
| upd_mask | input | STAT_W | Bits of the status that may be written |
| status | output | STAT_W | Held status register |

## Verification
The hardest case to reach is Z protection (R9) when the old Z differs from the computed Z. It needs a zero result under add-with-carry or a set extend flag, and it must follow an update that left Z at the opposite value. The stimulus therefore runs directed pairs: a move that sets or clears Z, followed by a zero-result add-with-carry or an extended add. The random phase draws operands and results from a pool that is heavy with zero, sign-boundary and all-ones values. This makes the pool hit zero-within-width results, both sign-rule branches and multiply high words equal to the sign extension.

// File: rtl/cc_flag_pkg.sv
package cc_flag_pkg;

  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;
  localparam int FLG_X = 4;
  localparam int FLG_R = 8;

  typedef enum logic [3:0] {
    OPC_ADD   = 4'd0,
    OPC_SUB   = 4'd1,
    OPC_CMP   = 4'd2,
    OPC_ADDC  = 4'd3,
    OPC_MOVE  = 4'd4,
    OPC_LOGIC = 4'd5,
    OPC_SHIFT = 4'd6,
    OPC_MULS  = 4'd7,
    OPC_MULU  = 4'd8,
    OPC_MCP   = 4'd9,
    OPC_LIVE  = 4'd10
  } opc_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } osz_e;

  typedef enum logic [2:0] {
    GRP_ARITH,
    GRP_NZ,
    GRP_MUL,
    GRP_MCP,
    GRP_LIVE
  } grp_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

  // Map a class code to the evaluator family that handles it.
  function automatic grp_e class_group(logic [3:0] op);
    grp_e g;
    case (op)
      OPC_MOVE, OPC_LOGIC, OPC_SHIFT: g = GRP_NZ;
      OPC_MULS, OPC_MULU:             g = GRP_MUL;
      OPC_MCP:                        g = GRP_MCP;
      OPC_LIVE:                       g = GRP_LIVE;
      default:                        g = GRP_ARITH;
    endcase
    return g;
  endfunction

  // Sign-bit rules: no carry chain, only the three MSBs and a zero test.
  function automatic nzvc_t sign_rules(logic r_msb, logic r_zero,
                                       logic s_msb, logic d_msb);
    nzvc_t f;
    f = '0;
    if (r_msb) begin
      f.n = 1'b1;
      f.v = ~s_msb & ~d_msb;
      f.c = s_msb & d_msb;
    end else begin
      f.z = r_zero;
      f.v = s_msb & d_msb;
      f.c = s_msb | d_msb;
    end
    return f;
  endfunction

endpackage

// File: rtl/cc_arith_eval.sv
module cc_arith_eval
  import cc_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        src_msbs,   // {word, half, byte} MSBs
  input  logic [2:0]        dst_msbs,
  input  logic [DATA_W-1:0] res,
  input  logic [1:0]        size,
  input  logic              invert,
  output nzvc_t             flags
);
  localparam int LANES  = 4;
  localparam int LANE_W = DATA_W / LANES;
  localparam int HALF_W = DATA_W / 2;

  logic [LANES-1:0] lane_zero;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_zero[g] = ~|res[g*LANE_W +: LANE_W];
    end
  endgenerate

  logic  r_msb, r_zero, s_msb, d_msb, sized;
  nzvc_t raw;

  always_comb begin
    r_msb  = 1'b0;
    r_zero = 1'b0;
    s_msb  = 1'b0;
    d_msb  = 1'b0;
    sized  = 1'b1;
    case (size)
      SZ_BYTE: begin
        r_msb  = res[LANE_W-1];
        r_zero = lane_zero[0];
        s_msb  = src_msbs[0];
        d_msb  = dst_msbs[0];
      end
      SZ_HALF: begin
        r_msb  = res[HALF_W-1];
        r_zero = &lane_zero[LANES/2-1:0];
        s_msb  = src_msbs[1];
        d_msb  = dst_msbs[1];
      end
      SZ_WORD: begin
        r_msb  = res[DATA_W-1];
        r_zero = &lane_zero;
        s_msb  = src_msbs[2];
        d_msb  = dst_msbs[2];
      end
      default: sized = 1'b0;
    endcase
    raw     = sized ? sign_rules(r_msb, r_zero, s_msb ^ invert, d_msb) : '0;
    flags   = raw;
    flags.c = raw.c ^ invert;
  end

endmodule

// File: rtl/cc_nz_eval.sv
module cc_nz_eval #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic              half_sel,
  output logic              n_flag,
  output logic              z_flag
);
  localparam int HALF_W = DATA_W / 2;

  logic hi_zero, lo_zero;

  always_comb begin
    lo_zero = ~|res[HALF_W-1:0];
    hi_zero = ~|res[DATA_W-1:HALF_W];
    if (half_sel) begin
      n_flag = res[HALF_W-1];
      z_flag = ~res[HALF_W-1] & lo_zero;
    end else begin
      n_flag = res[DATA_W-1];
      z_flag = ~res[DATA_W-1] & lo_zero & hi_zero;
    end
  end

endmodule

// File: rtl/cc_mul_eval.sv
module cc_mul_eval #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic [DATA_W-1:0] mof,
  input  logic              is_signed,
  output logic              n_flag,
  output logic              z_flag,
  output logic              v_flag
);
  logic [DATA_W-1:0] sext;

  always_comb begin
    sext   = {DATA_W{res[DATA_W-1]}};
    z_flag = ~|{mof, res};
    n_flag = ~z_flag & mof[DATA_W-1];
    v_flag = is_signed ? (mof != sext) : (|mof);
  end

endmodule

// File: rtl/cc_status_wb.sv
module cc_status_wb
  import cc_flag_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              hold_z,
  input  logic [STAT_W-1:0] calc,
  input  logic [STAT_W-1:0] mask,
  output logic [STAT_W-1:0] status
);
  localparam logic [STAT_W-1:0] X_BIT = STAT_W'(1) << FLG_X;
  localparam logic [STAT_W-1:0] Z_BIT = STAT_W'(1) << FLG_Z;

  logic [STAT_W-1:0] eff_mask, clr_mask, status_q;

  always_comb begin
    eff_mask = hold_z ? (mask & ~Z_BIT) : mask;
    clr_mask = eff_mask | X_BIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    status_q <= '0;
    else if (fire) status_q <= (status_q & ~clr_mask) | (calc & eff_mask);
  end

  assign status = status_q;

  p_x_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !status[FLG_X]);

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(status));

  p_unmasked_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((status ^ $past(status)) & ~$past(mask) & ~X_BIT) == '0);

endmodule

// File: rtl/cc_flag_engine.sv
module cc_flag_engine
  import cc_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [3:0]        op_class,
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] src_opnd,
  input  logic [DATA_W-1:0] dst_opnd,
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] mul_hi,
  input  logic              x_flag,
  input  logic [STAT_W-1:0] upd_mask,
  output logic [STAT_W-1:0] status
);
  localparam int LANE_W = DATA_W / 4;
  localparam int HALF_W = DATA_W / 2;

  grp_e              grp;
  logic              is_sub, word_sz, narrow_nz;
  logic [DATA_W-1:0] sum_w, diff_w, arith_res;
  logic [1:0]        arith_size;
  logic              arith_inv;
  logic [2:0]        src_msbs, dst_msbs;
  nzvc_t             a_flags;
  logic              nz_n, nz_z, mul_n, mul_z, mul_v;
  logic [STAT_W-1:0] calc;
  logic              hold_z, fire;

  always_comb begin
    grp        = class_group(op_class);
    is_sub     = (op_class == OPC_SUB) || (op_class == OPC_CMP);
    word_sz    = (op_size == SZ_WORD);
    narrow_nz  = (op_size == SZ_BYTE) || (op_size == SZ_RSVD);
    sum_w      = dst_opnd + src_opnd;
    diff_w     = dst_opnd - src_opnd;
    arith_size = (grp == GRP_MCP) ? SZ_WORD : op_size;
    arith_inv  = (grp == GRP_ARITH) && is_sub;
    arith_res  = result;
    if (grp == GRP_ARITH && word_sz && op_class == OPC_ADD) arith_res = sum_w;
    if (grp == GRP_ARITH && word_sz && op_class == OPC_SUB) arith_res = diff_w;
    src_msbs   = {src_opnd[DATA_W-1], src_opnd[HALF_W-1], src_opnd[LANE_W-1]};
    dst_msbs   = {dst_opnd[DATA_W-1], dst_opnd[HALF_W-1], dst_opnd[LANE_W-1]};
  end

  cc_arith_eval #(.DATA_W(DATA_W)) u_arith (
    .src_msbs (src_msbs),
    .dst_msbs (dst_msbs),
    .res      (arith_res),
    .size     (arith_size),
    .invert   (arith_inv),
    .flags    (a_flags)
  );

  cc_nz_eval #(.DATA_W(DATA_W)) u_nz (
    .res      (result),
    .half_sel (op_size == SZ_HALF),
    .n_flag   (nz_n),
    .z_flag   (nz_z)
  );

  cc_mul_eval #(.DATA_W(DATA_W)) u_mul (
    .res       (result),
    .mof       (mul_hi),
    .is_signed (op_class == OPC_MULS),
    .n_flag    (mul_n),
    .z_flag    (mul_z),
    .v_flag    (mul_v)
  );

  always_comb begin
    calc = '0;
    case (grp)
      GRP_ARITH: begin
        calc[FLG_N] = a_flags.n;
        calc[FLG_Z] = a_flags.z;
        calc[FLG_V] = a_flags.v;
        calc[FLG_C] = a_flags.c;
      end
      GRP_MCP: begin
        calc[FLG_N] = a_flags.n;
        calc[FLG_Z] = a_flags.z;
        calc[FLG_V] = a_flags.v;
        calc[FLG_R] = a_flags.c;
      end
      GRP_NZ: begin
        if (narrow_nz) begin
          calc[FLG_N] = a_flags.n;
          calc[FLG_Z] = a_flags.z;
          calc[FLG_V] = a_flags.v;
          calc[FLG_C] = a_flags.c;
        end else begin
          calc[FLG_N] = nz_n;
          calc[FLG_Z] = nz_z;
        end
      end
      GRP_MUL: begin
        calc[FLG_N] = mul_n;
        calc[FLG_Z] = mul_z;
        calc[FLG_V] = mul_v;
      end
      default: calc = '0;
    endcase
    hold_z = (x_flag || op_class == OPC_ADDC) && calc[FLG_Z];
    fire   = upd_valid && (grp != GRP_LIVE);
  end

  cc_status_wb #(.STAT_W(STAT_W)) u_wb (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .hold_z (hold_z),
    .calc   (calc),
    .mask   (upd_mask),
    .status (status)
  );

  p_live_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && grp == GRP_LIVE) |=> $stable(status));

  p_z_protected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hold_z) |=> status[FLG_Z] == $past(status[FLG_Z]));

  p_mcp_no_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && grp == GRP_MCP && upd_mask[FLG_C]) |=> !status[FLG_C]);

  p_nz_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && grp == GRP_NZ && !narrow_nz && !x_flag
     && upd_mask[FLG_N] && upd_mask[FLG_Z]) |=> !(status[FLG_N] && status[FLG_Z]));

  p_mulu_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_class == OPC_MULU && upd_mask[FLG_V])
      |=> status[FLG_V] == ($past(mul_hi) != '0));

endmodule

// File: tb/cc_flag_engine_test.sv
`timescale 1ns/1ps
module cc_flag_engine_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_valid;
  logic [3:0]  op_class;
  logic [1:0]  op_size;
  logic [31:0] src_opnd, dst_opnd, result, mul_hi;
  logic        x_flag;
  logic [15:0] upd_mask;
  logic [15:0] status;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] exp_st = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cc_flag_engine #(.DATA_W(32), .STAT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .op_class(op_class),
    .op_size(op_size), .src_opnd(src_opnd), .dst_opnd(dst_opnd),
    .result(result), .mul_hi(mul_hi), .x_flag(x_flag),
    .upd_mask(upd_mask), .status(status)
  );

  function automatic int width_of(logic [1:0] sz);
    case (sz)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 32;
      default: return 0;
    endcase
  endfunction

  // Returns {n, z, v, c}
  function automatic logic [3:0] ref_sign(int w, logic [31:0] s, logic [31:0] d,
                                          logic [31:0] r, logic inv);
    logic [31:0] lim;
    logic sm, dm, rm, n, z, v, c;
    if (w == 0) return {3'b000, inv};
    lim = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    sm = s[w-1] ^ inv;
    dm = d[w-1];
    rm = r[w-1];
    n  = rm;
    z  = !rm && ((r & lim) == 32'd0);
    v  = rm ? (!sm && !dm) : (sm && dm);
    c  = rm ? (sm && dm) : (sm || dm);
    return {n, z, v, c ^ inv};
  endfunction

  function automatic logic [15:0] ref_next(logic [15:0] st, logic v, logic [3:0] op,
      logic [1:0] sz, logic [31:0] s, logic [31:0] d, logic [31:0] r,
      logic [31:0] mof, logic x, logic [15:0] mask);
    logic [15:0] f, m;
    logic [3:0]  a;
    logic [63:0] wv;
    logic [31:0] rr;
    logic        inv;
    f = '0;
    if (!v || op == 4'd10) return st;
    case (op)
      4'd9: begin
        a = ref_sign(32, s, d, r, 1'b0);
        f[3] = a[3]; f[2] = a[2]; f[1] = a[1]; f[8] = a[0];
      end
      4'd7, 4'd8: begin
        wv = {mof, r};
        f[2] = (wv == 64'd0);
        f[3] = (wv != 64'd0) && wv[63];
        if (op == 4'd7) f[1] = ($signed(wv) != $signed({{32{r[31]}}, r}));
        else            f[1] = (mof != 32'd0);
      end
      4'd4, 4'd5, 4'd6: begin
        if (sz == 2'd2) begin
          f[3] = r[31]; f[2] = !r[31] && (r == 32'd0);
        end else if (sz == 2'd1) begin
          f[3] = r[15]; f[2] = !r[15] && (r[15:0] == 16'd0);
        end else begin
          a = ref_sign(width_of(sz), s, d, r, 1'b0);
          f[3:0] = a;
        end
      end
      default: begin
        inv = (op == 4'd1) || (op == 4'd2);
        rr  = r;
        if (sz == 2'd2 && op == 4'd0) rr = d + s;
        if (sz == 2'd2 && op == 4'd1) rr = d - s;
        a = ref_sign(width_of(sz), s, d, rr, inv);
        f[3:0] = a;
      end
    endcase
    m = mask;
    if ((x || op == 4'd3) && f[2]) m[2] = 1'b0;
    return (st & ~(m | 16'h0010)) | (f & m);
  endfunction

  function automatic string req_tag(logic v, logic [3:0] op, logic [1:0] sz);
    if (!v) return "R10";
    case (op)
      4'd10: return "R11";
      4'd9:  return "R5";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd4, 4'd5, 4'd6: return (sz == 2'd3) ? "R12" : "R6";
      default: begin
        if (sz == 2'd3) return "R12";
        if (op == 4'd1 || op == 4'd2) return "R3";
        if (sz == 2'd2 && op == 4'd0) return "R4";
        return "R2";
      end
    endcase
  endfunction

  task automatic check(logic [15:0] act, logic [15:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: status=%h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(logic v, logic [3:0] op, logic [1:0] sz, logic [31:0] s,
                      logic [31:0] d, logic [31:0] r, logic [31:0] mof, logic x,
                      logic [15:0] mask, string tag);
    upd_valid = v; op_class = op; op_size = sz; src_opnd = s; dst_opnd = d;
    result = r; mul_hi = mof; x_flag = x; upd_mask = mask;
    exp_st = ref_next(exp_st, v, op, sz, s, d, r, mof, x, mask);
    @(negedge clk);
    check(status, exp_st, (tag == "") ? req_tag(v, op, sz) : tag);
    if (status !== exp_st) exp_st = status;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 10)
      0: return 32'd0;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h0000_0080;
      5: return 32'h0000_8000;
      6: return $urandom % 4;
      7: return 32'hFFFF_FF00;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; upd_valid = 1'b0; op_class = '0; op_size = '0;
    src_opnd = '0; dst_opnd = '0; result = '0; mul_hi = '0; x_flag = 1'b0;
    upd_mask = '0;
    repeat (3) @(negedge clk);
    check(status, 16'h0000, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(status, 16'h0000, "R1 after release");

    // R4: word add recomputes dst+src, result input ignored
    step(1, 4'd0, 2'd2, 32'h1, 32'h7FFF_FFFF, 32'h0, 32'h0, 0, 16'hFFFF, "R4 word add");
    check(status, 16'h000A, "R4 literal N|V");
    step(1, 4'd1, 2'd2, 32'h5, 32'h5, 32'h1234, 32'h0, 0, 16'hFFFF, "R3 word sub zero");
    check(status, 16'h0004, "R3 literal Z only");
    step(1, 4'd2, 2'd2, 32'h2, 32'h1, 32'hFFFF_FFFF, 32'h0, 0, 16'hFFFF, "R4 cmp uses result");
    step(1, 4'd0, 2'd0, 32'h80, 32'h80, 32'h100, 32'h0, 0, 16'hFFFF, "R2 byte add");
    check(status, 16'h0007, "R2 literal Z|V|C");
    step(1, 4'd1, 2'd1, 32'h8000, 32'h0001, 32'h8001, 32'h0, 0, 16'hFFFF, "R3 half sub");
    step(1, 4'd9, 2'd0, 32'h8000_0000, 32'h0, 32'h1, 32'h0, 0, 16'hFFFF, "R5 block copy");
    check(status, 16'h0100, "R5 literal R only");
    step(1, 4'd4, 2'd2, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, 0, 16'hFFFF, "R6 move word zero");
    step(1, 4'd5, 2'd1, 32'h0, 32'h0, 32'h0001_8000, 32'h0, 0, 16'hFFFF, "R6 logic half neg");
    step(1, 4'd6, 2'd0, 32'h80, 32'h80, 32'h7F, 32'h0, 0, 16'hFFFF, "R6 shift byte arith");
    step(1, 4'd7, 2'd2, 32'h0, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 16'hFFFF, "R7 muls fits");
    step(1, 4'd7, 2'd2, 32'h0, 32'h0, 32'h0000_0001, 32'hFFFF_FFFF, 0, 16'hFFFF, "R7 muls overflow");
    step(1, 4'd8, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 0, 16'hFFFF, "R8 mulu zero");
    step(1, 4'd8, 2'd2, 32'h0, 32'h0, 32'h5, 32'h2, 0, 16'hFFFF, "R8 mulu high");

    // R9: Z protection with both old values
    step(1, 4'd4, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 0, 16'hFFFF, "R9 setup Z=1");
    step(1, 4'd3, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 0, 16'hFFFF, "R9 addc keeps Z=1");
    check(status, 16'h0004, "R9 literal Z held");
    step(1, 4'd4, 2'd2, 32'h0, 32'h0, 32'h1, 32'h0, 0, 16'hFFFF, "R9 setup Z=0");
    step(1, 4'd3, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 0, 16'hFFFF, "R9 addc keeps Z=0");
    check(status, 16'h0000, "R9 literal Z not set");
    step(1, 4'd0, 2'd1, 32'h0, 32'h0, 32'h0, 32'h0, 1, 16'hFFFF, "R9 x set keeps Z");

    // R10/R11/R12
    step(1, 4'd8, 2'd2, 32'h0, 32'h0, 32'h1, 32'h1, 0, 16'hFFFF, "R10 prime V");
    step(1, 4'd4, 2'd2, 32'h0, 32'h0, 32'h8000_0000, 32'h0, 0, 16'h0008, "R10 partial mask");
    check(status, 16'h000A, "R10 literal V kept N set");
    step(0, 4'd4, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 0, 16'hFFFF, "R10 no strobe");
    step(1, 4'd10, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 1, 16'hFFFF, "R11 live");
    check(status, 16'h000A, "R11 literal unchanged");
    step(1, 4'd1, 2'd3, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 0, 16'hFFFF, "R12 reserved sub");
    step(1, 4'd4, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0, 0, 16'hFFFF, "R12 reserved move");

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] s, d, r, mof;
      logic [3:0]  op;
      logic [15:0] mask;
      s  = pick();
      d  = pick();
      r  = pick();
      op = 4'($urandom % 16);
      case ($urandom % 4)
        0: mof = 32'd0;
        1: mof = {32{r[31]}};
        2: mof = 32'hFFFF_FFFF;
        default: mof = $urandom;
      endcase
      mask = (($urandom % 4) == 0) ? 16'($urandom) : 16'hFFFF;
      step(($urandom % 8) != 0, op, 2'($urandom % 4), s, d, r, mof,
           ($urandom % 4) == 0, mask, "");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule